// File: doc/BRIEF.md
# Processor Interrupt Poll Unit

This block sits next to the instruction sequencer of a small 8-bit processor core. It decides, at each instruction boundary, whether the next step is an ordinary opcode fetch or entry into an interrupt handler. It watches two active-low interrupt pins. The non-maskable line is handled by a falling-edge catcher that holds its result until the sequencer acknowledges it. The maskable line is handled by a plain level test that is gated by the processor's interrupt-disable flag.

Neither detector acts on its own. Both are consulted only while the sequencer raises its "last cycle of this instruction" strobe. In that cycle the block raises at most one of two request outputs, and the non-maskable request wins a tie. A pin that changes in the middle of an instruction affects nothing until the next strobe. Vector fetch, stack pushes and flag updates stay in the sequencer. The interface is plain control wiring, so it has no valid/ready handshake: the strobe is the only qualifier, and the outputs cannot be stalled.

Top module: `irq_poll_unit`

## Requirements
- R1: After reset, with both pins held high (inactive), a poll yields take_nmi = 0 and take_irq = 0.
- R2: Pins pass through a two-stage synchronizer. A non-maskable falling edge driven before clock edge k is latched at edge k+2 and reported by polls from edge k+2 on. A maskable low level driven before edge k is seen by polls from edge k+1 on.
- R3: take_nmi and take_irq are 1 only in a cycle where insn_last is 1. A pin change that comes and goes between two polls produces no request.
- R4: The non-maskable latch sets on a 1-to-0 transition of the synchronized nmi_n. Holding nmi_n low after an acknowledge does not set the latch again.
- R5: Once set, the non-maskable latch stays set until nmi_ack, even if nmi_n returns high. Every poll before the acknowledge reports take_nmi = 1.
- R6: nmi_ack = 1 at a clock edge clears the latch. If a new falling edge is detected at that same edge, the latch stays set.
- R7: take_irq = 1 at a poll only while the synchronized irq_n is low. The maskable side holds no memory.
- R8: irq_mask = 1 suppresses take_irq. take_nmi is unaffected by irq_mask.
- R9: When the non-maskable latch is set and the maskable level is active at the same poll, only take_nmi is 1.
- R10: take_nmi and take_irq are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| irq_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| irq_mask | input | 1 | Interrupt-disable flag from the status register; 1 blocks the maskable request |
| insn_last | input | 1 | Strobe from the sequencer marking the final cycle of the current instruction |
| nmi_ack | input | 1 | One-cycle pulse from the sequencer when non-maskable entry begins |
| take_nmi | output | 1 | Enter the non-maskable handler instead of fetching the next opcode |
| take_irq | output | 1 | Enter the maskable handler instead of fetching the next opcode |

## Verification
Two collisions matter here. The first is a falling edge reaching the latch in the very clock edge that carries nmi_ack. The bench provokes it by placing the acknowledge pulse two cycles after the pin drop, then expects the next poll to report take_nmi. The second is both interrupt sources being pending at one poll. The bench holds irq_n low while latching a non-maskable edge, expects take_nmi alone, and after the acknowledge expects the maskable request to surface at the following poll.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  // Index of each pin inside the bundled synchronizer vector
  localparam int PIN_NMI   = 0;
  localparam int PIN_IRQ   = 1;
  localparam int PIN_COUNT = 2;

  // Decision made at an instruction boundary
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_IRQ  = 2'd1,
    KIND_NMI  = 2'd2
  } int_kind_e;

endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  // Plain flop chain; every bit resets to its inactive level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irqp_nmi_edge.sv
module irqp_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,   // synchronized, active low
  input  logic ack,
  output logic pend,
  output logic fall
);

  logic prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= line_n;
  end

  // A single cycle marker for the high-to-low step only
  assign fall = prev_n & ~line_n;

  // A set takes precedence over a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (fall) pend <= 1'b1;
    else if (ack)  pend <= 1'b0;
  end

endmodule

// File: rtl/irqp_irq_level.sv
module irqp_irq_level (
  input  logic line_n,   // synchronized, active low
  input  logic mask,
  output logic req
);

  // No storage: the request follows the line while unmasked
  assign req = ~line_n & ~mask;

endmodule

// File: rtl/irqp_poll_arb.sv
module irqp_poll_arb
  import irqp_pkg::*;
(
  input  logic poll,
  input  logic nmi_pend,
  input  logic irq_req,
  output logic take_nmi,
  output logic take_irq
);

  int_kind_e kind;

  always_comb begin
    kind = KIND_NONE;
    if (poll) begin
      if (nmi_pend)     kind = KIND_NMI;
      else if (irq_req) kind = KIND_IRQ;
    end
  end

  assign take_nmi = (kind == KIND_NMI);
  assign take_irq = (kind == KIND_IRQ);

endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
  import irqp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic irq_mask,
  input  logic insn_last,
  input  logic nmi_ack,
  output logic take_nmi,
  output logic take_irq
);

  logic [PIN_COUNT-1:0] pin_raw;
  logic [PIN_COUNT-1:0] pin_s;
  logic nmi_s;
  logic irq_s;
  logic nmi_pend;
  logic nmi_fall;
  logic irq_req;

  always_comb begin
    pin_raw          = '1;
    pin_raw[PIN_NMI] = nmi_n;
    pin_raw[PIN_IRQ] = irq_n;
  end

  irqp_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (pin_s)
  );

  assign nmi_s = pin_s[PIN_NMI];
  assign irq_s = pin_s[PIN_IRQ];

  irqp_nmi_edge u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .line_n(nmi_s),
    .ack   (nmi_ack),
    .pend  (nmi_pend),
    .fall  (nmi_fall)
  );

  irqp_irq_level u_irq (
    .line_n(irq_s),
    .mask  (irq_mask),
    .req   (irq_req)
  );

  irqp_poll_arb u_arb (
    .poll    (insn_last),
    .nmi_pend(nmi_pend),
    .irq_req (irq_req),
    .take_nmi(take_nmi),
    .take_irq(take_irq)
  );

endmodule

// File: rtl/irq_poll_chk.sv
module irq_poll_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_mask,
  input logic insn_last,
  input logic nmi_ack,
  input logic take_nmi,
  input logic take_irq,
  input logic nmi_s,
  input logic irq_s,
  input logic nmi_pend,
  input logic nmi_fall
);

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_irq})); // R10

  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi || take_irq) |-> insn_last); // R3

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !irq_mask); // R8

  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !irq_s); // R7

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_last && nmi_pend) |-> (take_nmi && !take_irq)); // R9

  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> $past(!nmi_s)); // R4

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_ack) |=> nmi_pend); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !nmi_fall) |=> !nmi_pend); // R6

endmodule

bind irq_poll_unit irq_poll_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_mask (irq_mask),
  .insn_last(insn_last),
  .nmi_ack  (nmi_ack),
  .take_nmi (take_nmi),
  .take_irq (take_irq),
  .nmi_s    (nmi_s),
  .irq_s    (irq_s),
  .nmi_pend (nmi_pend),
  .nmi_fall (nmi_fall)
);

// File: tb/irq_poll_unit_tb.sv
module irq_poll_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1;
  logic irq_n = 1'b1;
  logic irq_mask = 1'b0;
  logic insn_last = 1'b0;
  logic nmi_ack = 1'b0;
  logic take_nmi;
  logic take_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  irq_poll_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_n    (nmi_n),
    .irq_n    (irq_n),
    .irq_mask (irq_mask),
    .insn_last(insn_last),
    .nmi_ack  (nmi_ack),
    .take_nmi (take_nmi),
    .take_irq (take_irq)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {take_nmi,take_irq} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one poll cycle, expectation queued for the monitor
  task automatic poll(input logic en, input logic ei, input string tag);
    @(negedge clk);
    insn_last = 1'b1;
    exp_q.push_back({en, ei});
    tag_q.push_back(tag);
    @(posedge clk);
    #1 insn_last = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    nmi_ack = 1'b1;
    @(posedge clk);
    #1 nmi_ack = 1'b0;
  endtask

  task automatic set_nmi(input logic v);
    @(negedge clk);
    nmi_n = v;
  endtask

  task automatic set_irq(input logic v);
    @(negedge clk);
    irq_n = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares at every poll, and checks silence elsewhere (R3)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && !done) begin
        if (take_nmi && take_irq) check("R10", {take_nmi, take_irq}, 2'b10);
        if (insn_last) begin
          if (exp_q.size() == 0) begin
            check("R3", 2'bxx, 2'b00);
          end else begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {take_nmi, take_irq}, e);
          end
        end else if (take_nmi || take_irq) begin
          check("R3", {take_nmi, take_irq}, 2'b00);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 quiet after reset
    poll(1'b0, 1'b0, "R1");

    // R2 edge latency: latched on the third edge after the drop
    set_nmi(1'b0);
    poll(1'b0, 1'b0, "R2");
    poll(1'b0, 1'b0, "R2");
    poll(1'b1, 1'b0, "R2");

    // R5 held across pin release until acknowledged
    set_nmi(1'b1);
    idle(3);
    poll(1'b1, 1'b0, "R5");
    poll(1'b1, 1'b0, "R5");
    ack();
    poll(1'b0, 1'b0, "R6");

    // R4 a held-low line does not retrigger
    set_nmi(1'b0);
    idle(3);
    poll(1'b1, 1'b0, "R4");
    ack();
    idle(3);
    poll(1'b0, 1'b0, "R4");
    set_nmi(1'b1);
    idle(3);

    // R6 edge and acknowledge at the same clock edge
    set_nmi(1'b0);
    @(negedge clk);
    ack();
    idle(2);
    poll(1'b1, 1'b0, "R6");
    ack();
    set_nmi(1'b1);
    idle(3);
    poll(1'b0, 1'b0, "R6");

    // R2 level latency
    set_irq(1'b0);
    poll(1'b0, 1'b0, "R2");
    poll(1'b0, 1'b1, "R2");

    // R7 release removes the request; short pulse between polls ignored (R3)
    set_irq(1'b1);
    idle(3);
    poll(1'b0, 1'b0, "R7");
    set_irq(1'b0);
    set_irq(1'b1);
    idle(3);
    poll(1'b0, 1'b0, "R7");
    set_irq(1'b0);
    idle(3);
    poll(1'b0, 1'b1, "R7");
    poll(1'b0, 1'b1, "R7");

    // R8 mask blocks level but not edge
    @(negedge clk);
    irq_mask = 1'b1;
    poll(1'b0, 1'b0, "R8");
    set_nmi(1'b0);
    idle(3);
    poll(1'b1, 1'b0, "R8");
    ack();
    set_nmi(1'b1);
    @(negedge clk);
    irq_mask = 1'b0;
    poll(1'b0, 1'b1, "R8");

    // R9 both pending: edge first, level afterwards
    set_nmi(1'b0);
    idle(3);
    poll(1'b1, 1'b0, "R9");
    ack();
    poll(1'b0, 1'b1, "R9");
    set_nmi(1'b1);
    set_irq(1'b1);
    idle(3);
    poll(1'b0, 1'b0, "R9");

    idle(3);
    if (exp_q.size() != 0) check("R3", 2'b11, 2'b00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule